// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This bridge serves an address window where every 32-bit alias word stands for exactly one bit of a smaller target region. A slave port takes byte, halfword or word accesses aimed at the window. A master port then makes the matching access to the target memory. A read returns the chosen target bit as the value 0 or 1. A write turns into a read-modify-write that changes only that bit, to the value of write-data bit 0.

The alias base, the target base and the window size are parameters, so one module serves every region. An SRAM region and a peripheral region are the usual pair. The slave side holds a request until `s_ready` pulses. The master side issues one-cycle request pulses and waits for `m_ack`. Byte lanes on the master bus are little-endian.

Top module: `bit_alias_bridge`

## Requirements
- R1: The offset is (`s_addr` − ALIAS_BASE) reduced to WIN_BITS bits. The target unit address on `m_addr` is TARGET_BASE OR (offset >> 5). Its low bit is cleared for halfword accesses, and its two low bits are cleared for word accesses.
- R2: `s_size` selects the access width: 0 is byte, 1 is halfword, 2 (and 3) is word. The bit index is (offset >> 2) taken modulo 8, 16 or 32 for byte, halfword or word.
- R3: A read completes with `s_rdata` equal to 1 when the selected target bit is set and 0 otherwise, with bits 31:1 zero.
- R4: A write sets the selected target bit when `s_wdata[0]` is 1 and clears it when it is 0. `s_wdata[31:1]` has no effect, and every other bit of the target unit keeps its value.
- R5: A write issues exactly one master read followed by exactly one master write, both to the same unit address with the same byte enables. The completion returns `s_rdata` = 0.
- R6: A read issues exactly one master read and no master write.
- R7: `s_ready` stays low until the last master transfer of the access has been acknowledged, then goes high for exactly one cycle. No new access is accepted while one is in progress.
- R8: `m_be` selects the little-endian lanes of the unit. A byte uses 1 << addr[1:0], a halfword uses 0b0011 << addr[1:0], and a word uses 0b1111.
- R9: While reset is asserted, `m_req` and `s_ready` are low.
- R10: Address bits at and above bit WIN_BITS of the offset have no effect. Alias addresses that differ only there reach the same target bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Alias access request, held until s_ready |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | Access width code |
| s_addr | input | 32 | Alias byte address |
| s_wdata | input | 32 | Write data, only bit 0 used |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result (0 or 1) |
| m_req | output | 1 | One-cycle target request pulse |
| m_we | output | 1 | Target write when high |
| m_addr | output | 32 | Target unit byte address |
| m_be | output | 4 | Target byte-lane enables |
| m_wdata | output | 32 | Modified target data |
| m_ack | input | 1 | Target transfer complete |
| m_rdata | input | 32 | Target read data |

## Verification
The bench builds the bridge with WIN_BITS = 13 and keeps the default bases. The target region then shrinks to 256 bytes behind 2048 alias words, so it becomes practical to sweep every alias word at every access width, both for reads and for writes. Each sweep address also carries junk in bits 13 to 14, which exercises the wrap of the window. The target memory answers after latencies of one or two cycles, in alternation, so that the wait states see both cases.

// File: rtl/bab_pkg.sv
package bab_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] mask;
    } xlate_t;

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] mask;
        logic              write;
        logic              wbit;
        logic [DATA_W-1:0] wdata;
        logic              rdy;
        logic              rbit;
    } seq_regs_t;

endpackage

// File: rtl/bab_xlate.sv
module bab_xlate
    import bab_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h2000_0000,
    parameter int                WIN_BITS    = 25
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output xlate_t            xl
);

    localparam int WORD_SHIFT = 5;   // one alias word (32 bits) per target bit
    localparam int IDX_W      = $clog2(DATA_W);

    logic [ADDR_W-1:0]   diff;
    logic [WIN_BITS-1:0] off;
    logic [ADDR_W-1:0]   unit;
    logic [ADDR_W-1:0]   aligned;
    logic [IDX_W-1:0]    bidx;
    logic [IDX_W-1:0]    pos;
    logic                unused_bits;

    always_comb begin
        diff = addr - ALIAS_BASE;
        off  = diff[WIN_BITS-1:0];
        unit = TARGET_BASE | (ADDR_W'(off) >> WORD_SHIFT);
        case (size)
            SZ_BYTE: begin
                aligned = unit;
                bidx    = {2'b00, off[4:2]};
                xl.be   = 4'b0001 << unit[1:0];
            end
            SZ_HALF: begin
                aligned = {unit[ADDR_W-1:1], 1'b0};
                bidx    = {1'b0, off[5:2]};
                xl.be   = 4'b0011 << {unit[1], 1'b0};
            end
            default: begin
                aligned = {unit[ADDR_W-1:2], 2'b00};
                bidx    = off[6:2];
                xl.be   = 4'b1111;
            end
        endcase
        pos     = {aligned[1:0], 3'b000} + bidx;
        xl.mask = DATA_W'(1) << pos;
        xl.addr = aligned;
    end

    assign unused_bits = ^{diff, off[1:0]};

endmodule

// File: rtl/bab_seq.sv
module bab_seq
    import bab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_write,
    input  logic              s_wbit,
    input  xlate_t            xl,
    output logic              s_ready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [BE_W-1:0]   m_be,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ack,
    input  logic [DATA_W-1:0] m_rdata
);

    seq_regs_t q, d;

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                d.rdy = 1'b0;
                if (s_req && !q.rdy) begin
                    d.addr  = xl.addr;
                    d.be    = xl.be;
                    d.mask  = xl.mask;
                    d.write = s_write;
                    d.wbit  = s_wbit;
                    d.state = ST_RD_REQ;
                end
            end
            ST_RD_REQ:  d.state = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (m_ack) begin
                    if (q.write) begin
                        d.wdata = q.wbit ? (m_rdata | q.mask) : (m_rdata & ~q.mask);
                        d.state = ST_WR_REQ;
                    end else begin
                        d.rbit  = |(m_rdata & q.mask);
                        d.rdy   = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_WR_REQ:  d.state = ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (m_ack) begin
                    d.rbit  = 1'b0;
                    d.rdy   = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default:    d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign m_req   = (q.state == ST_RD_REQ) || (q.state == ST_WR_REQ);
    assign m_we    = (q.state == ST_WR_REQ);
    assign m_addr  = q.addr;
    assign m_be    = q.be;
    assign m_wdata = q.wdata;
    assign s_ready = q.rdy;
    assign s_rdata = {{(DATA_W-1){1'b0}}, q.rbit};

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req); // R6
    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready); // R7
    AST_NO_RDY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) |-> !s_ready); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE && $past(q.state) != ST_IDLE) |-> ($stable(m_addr) && $stable(m_be))); // R5
    AST_MASK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) |-> ($countones(q.mask) == 1)); // R2
    AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> (m_be == 4'hF || m_be == 4'h3 || m_be == 4'hC || $countones(m_be) == 1)); // R8
    AST_MASK_IN_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ((q.mask & {{8{m_be[3]}}, {8{m_be[2]}}, {8{m_be[1]}}, {8{m_be[0]}}}) == q.mask)); // R8

endmodule

// File: rtl/bit_alias_bridge.sv
module bit_alias_bridge
    import bab_pkg::*;
#(
    parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
    parameter logic [31:0] TARGET_BASE = 32'h2000_0000,
    parameter int          WIN_BITS    = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_req,
    input  logic        s_write,
    input  logic [1:0]  s_size,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic [31:0] s_rdata,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [3:0]  m_be,
    output logic [31:0] m_wdata,
    input  logic        m_ack,
    input  logic [31:0] m_rdata
);

    xlate_t xl;
    logic   unused_wdata;

    bab_xlate #(
        .ALIAS_BASE  (ALIAS_BASE),
        .TARGET_BASE (TARGET_BASE),
        .WIN_BITS    (WIN_BITS)
    ) u_xlate (
        .addr (s_addr),
        .size (s_size),
        .xl   (xl)
    );

    bab_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_req   (s_req),
        .s_write (s_write),
        .s_wbit  (s_wdata[0]),
        .xl      (xl),
        .s_ready (s_ready),
        .s_rdata (s_rdata),
        .m_req   (m_req),
        .m_we    (m_we),
        .m_addr  (m_addr),
        .m_be    (m_be),
        .m_wdata (m_wdata),
        .m_ack   (m_ack),
        .m_rdata (m_rdata)
    );

    assign unused_wdata = ^s_wdata[31:1];

    AST_IDLE_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> (!m_req && !s_ready)); // R9

endmodule

// File: tb/bit_alias_bridge_test.sv
module bit_alias_bridge_test;

    localparam logic [31:0] ABASE = 32'h2200_0000;
    localparam logic [31:0] TBASE = 32'h2000_0000;
    localparam int          WBITS = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0;
    logic        s_write = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        m_req;
    logic        m_we;
    logic [31:0] m_addr;
    logic [3:0]  m_be;
    logic [31:0] m_wdata;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;

    bit_alias_bridge #(.ALIAS_BASE(ABASE), .TARGET_BASE(TBASE), .WIN_BITS(WBITS)) uut (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_write(s_write), .s_size(s_size),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata)
    );

    always #5 clk = ~clk;

    logic [7:0] mb [256];   // target memory model
    logic [7:0] rb [256];   // expected image
    int rd_cnt = 0, wr_cnt = 0, wr_done = 0, nreq = 0;
    logic [31:0] lr_addr = '0, lw_addr = '0;
    logic [3:0]  lr_be = '0, lw_be = '0;
    int vecs = 0, errs = 0;
    bit done = 1'b0;

    always begin
        @(negedge clk);
        while (rst_n && m_req) begin
            logic [31:0] a, wd;
            logic [3:0]  be;
            logic        we;
            int          base;
            a = m_addr; we = m_we; be = m_be; wd = m_wdata;
            if (we) begin wr_cnt++; lw_addr = a; lw_be = be; end
            else    begin rd_cnt++; lr_addr = a; lr_be = be; end
            repeat (1 + (nreq % 2)) @(negedge clk);
            nreq++;
            base = {24'd0, a[7:2], 2'b00};
            m_rdata = {mb[base+3], mb[base+2], mb[base+1], mb[base]};
            if (we) begin
                for (int k = 0; k < 4; k++)
                    if (be[k]) mb[base+k] = wd[8*k +: 8];
                wr_done++;
            end
            m_ack = 1'b1;
            @(negedge clk);
            m_ack = 1'b0;
        end
    end

    function automatic logic [7:0] hb(int i);
        return 8'((i * 37 + 11) ^ ((i >> 2) * 5));
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] addr, input logic [1:0] sz, input logic wr,
                          input logic [31:0] wd, output logic [31:0] rd, output int wdone_at_rdy);
        s_req = 1'b1; s_write = wr; s_size = sz; s_addr = addr; s_wdata = wd;
        do @(negedge clk); while (!s_ready);
        rd = s_rdata;
        wdone_at_rdy = wr_done;
        s_req = 1'b0;
        @(negedge clk);
        chk(!s_ready, "R7 ready pulse length", {31'd0, s_ready}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++; vecs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, addr, wd, exp_addr, word, expw;
        logic [3:0]  exp_be;
        int off, unitb, al, bi, byt, r0, w0, wdn, amask, base;
        logic bitv, wbit;

        for (int i = 0; i < 256; i++) begin mb[i] = hb(i); rb[i] = hb(i); end
        repeat (3) @(negedge clk);
        chk(!m_req, "R9 m_req in reset", {31'd0, m_req}, 32'd0);
        chk(!s_ready, "R9 s_ready in reset", {31'd0, s_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // read sweep: every alias word, every width
        for (int sz = 0; sz < 3; sz++) begin
            for (int w = 0; w < 2048; w++) begin
                off   = w * 4 + (w % 4);
                addr  = ABASE + 32'(off) + (32'(w % 4) << WBITS);   // R10 junk above window
                amask = (sz == 0) ? 0 : (sz == 1) ? 1 : 3;
                unitb = off >> 5;
                al    = unitb & ~amask;
                bi    = (off >> 2) & ((8 << sz) - 1);
                byt   = al + bi / 8;
                bitv  = rb[byt][bi % 8];
                exp_addr = TBASE | 32'(al);
                exp_be   = (sz == 0) ? 4'(1 << (al % 4)) : (sz == 1) ? 4'(3 << (al % 4)) : 4'hF;
                r0 = rd_cnt; w0 = wr_cnt;
                access(addr, 2'(sz), 1'b0, 32'hFFFF_FFFE, rd, wdn);
                chk(rd == {31'd0, bitv}, "R3 R2 read bit value", rd, {31'd0, bitv});
                chk(lr_addr == exp_addr, "R1 R10 read unit address", lr_addr, exp_addr);
                chk(lr_be == exp_be, "R8 read byte enables", {28'd0, lr_be}, {28'd0, exp_be});
                chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R6 read transfer count",
                    32'(rd_cnt - r0 + 16 * (wr_cnt - w0)), 32'd1);
            end
        end

        // write sweep: every alias word, every width
        for (int sz = 0; sz < 3; sz++) begin
            for (int w = 0; w < 2048; w++) begin
                off   = w * 4 + ((w >> 3) % 4);
                addr  = ABASE + 32'(off) + (32'((w >> 1) % 4) << WBITS);
                amask = (sz == 0) ? 0 : (sz == 1) ? 1 : 3;
                unitb = off >> 5;
                al    = unitb & ~amask;
                bi    = (off >> 2) & ((8 << sz) - 1);
                byt   = al + bi / 8;
                wbit  = hb(w * 3 + sz)[0];
                wd    = {24'(w * 77), 7'h5A, wbit};
                rb[byt][bi % 8] = wbit;
                exp_addr = TBASE | 32'(al);
                exp_be   = (sz == 0) ? 4'(1 << (al % 4)) : (sz == 1) ? 4'(3 << (al % 4)) : 4'hF;
                r0 = rd_cnt; w0 = wr_cnt;
                access(addr, 2'(sz), 1'b1, wd, rd, wdn);
                chk(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R5 write transfer count",
                    32'(rd_cnt - r0 + 16 * (wr_cnt - w0)), 32'd17);
                chk(lr_addr == exp_addr && lw_addr == exp_addr, "R5 R1 write unit address", lw_addr, exp_addr);
                chk(lr_be == exp_be && lw_be == exp_be, "R8 R5 write byte enables",
                    {24'd0, lr_be, lw_be}, {24'd0, exp_be, exp_be});
                chk(wdn == wr_cnt, "R7 ready after write ack", 32'(wdn), 32'(wr_cnt));
                chk(rd == 32'd0, "R5 write response data", rd, 32'd0);
                base = al & ~3;
                word = {mb[base+3], mb[base+2], mb[base+1], mb[base]};
                expw = {rb[base+3], rb[base+2], rb[base+1], rb[base]};
                chk(word == expw, "R4 target word after write", word, expw);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule